// File: doc/BRIEF.md
# Five-Pass RAM March Tester

This block is a built-in test engine for a 16-bit-wide synchronous single-port RAM. After a start pulse it drives the RAM's address, write-data and write-enable lines through a fixed march of five passes. The passes use all-zeros and all-ones words and alternate between ascending and descending address order. The march works on a window of `2**WIN_W` words. It runs once for every window base, in ascending base order, so the whole `2**ADDR_W`-word space is covered.

Each check pass spends two cycles per address. In the first cycle it issues a read. In the second cycle it compares the returned word (one cycle of read latency) and writes the new pattern to the same address. Only then does the address step on. A mismatch never halts the run. Differing bits are ORed into a sticky error mask. The address of the first mismatch is latched, and a fault map gets one bit per RAM device, selected by the top `BANK_W` address bits. At the end `done` pulses for one cycle, and `pass_ok` reports whether the whole run was clean.

Top module: `march_tester`

## Requirements
- R1: Pass 1 writes 0x0000 to every address of the window, ascending from offset 0. It issues no reads.
- R2: Pass 2 walks the window from the top offset down to 0. At each address it reads, expects 0x0000, and in the next cycle writes 0xFFFF to that same address.
- R3: Pass 3 walks the window upward. At each address it reads, expects 0xFFFF, then writes 0x0000 to the same address.
- R4: Pass 4 walks the window upward. At each address it reads, expects 0x0000, then writes 0xFFFF to the same address.
- R5: Pass 5 walks the window downward. At each address it reads, expects 0xFFFF, then writes 0x0000 to the same address.
- R6: The RAM address is {window index, offset}. Windows run from index 0 upward, and each window gets all five passes. `done` rises exactly 9·2^WIN_W·2^(ADDR_W−WIN_W) clock edges after the edge that accepts start.
- R7: A mismatch does not stop the run. `err_bits` is the OR of (read word XOR expected word) over all checks, and its bits never clear during a run.
- R8: `fail_addr` holds the address of the first mismatching read in march order. Later mismatches do not change it.
- R9: Bit b of `bank_bad` is set if and only if a mismatch occurred at an address whose top BANK_W bits equal b.
- R10: `done` is high for exactly one cycle. At that cycle `pass_ok` is 1 only if no mismatch occurred. All results hold until the next accepted start.
- R11: A start seen while busy is ignored. An accepted start clears all results.
- R12: After reset, `busy`, `done`, `pass_ok`, `err_bits`, `fail_addr`, `bank_bad` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, taken only when idle |
| busy | output | 1 | March in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass_ok | output | 1 | Run finished with no mismatch |
| fail_addr | output | ADDR_W | Address of first mismatch |
| err_bits | output | DATA_W | Sticky OR of failing bit positions |
| bank_bad | output | 2**BANK_W | Per-device fault map |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | DATA_W | RAM write data |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after the address |

## Verification
The bench runs the march against a RAM model with no faults, then with directed stuck-at cells. The directed cells are a stuck-at-1 bit at address 0 and a stuck-at-0 bit at the top address, and together they separate the descending passes from the ascending ones in the first-fail address. Further runs have faults in both devices, which exercises the per-device map, and randomly placed stuck-at-0 and stuck-at-1 bits, which exercise OR accumulation across cells. Every RAM operation is logged and compared, per pass, against the bench's own rendering of the march. This catches wrong direction, wrong pattern, a missing read-then-write pairing and wrong window order. A start pulse in the middle of a run shows that the run is neither restarted nor lengthened.

// File: rtl/march_pkg.sv
package march_pkg;

  localparam int unsigned PASS_NUM   = 5;
  localparam int unsigned PASS_IDX_W = 3;

  typedef logic [PASS_IDX_W-1:0] pass_idx_t;

  localparam pass_idx_t PASS_FIRST = '0;
  localparam pass_idx_t PASS_LAST  = pass_idx_t'(PASS_NUM - 1);

  // passes 1 and 4 (zero-based) walk from the top offset downward
  function automatic logic pass_is_desc(pass_idx_t p);
    return (p == 3'd1) || (p == 3'd4);
  endfunction

  // every pass but the initial fill reads before writing
  function automatic logic pass_reads(pass_idx_t p);
    return p != PASS_FIRST;
  endfunction

  // pattern written by a pass: 1 means all ones
  function automatic logic pass_write_ones(pass_idx_t p);
    return (p == 3'd1) || (p == 3'd3);
  endfunction

  // pattern expected on read: 1 means all ones
  function automatic logic pass_expect_ones(pass_idx_t p);
    return (p == 3'd2) || (p == 3'd4);
  endfunction

  // cycles one window costs: a single-cycle fill plus four two-cycle passes
  function automatic int unsigned cycles_per_window(int unsigned words);
    return words + (PASS_NUM - 1) * 2 * words;
  endfunction

endpackage

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              finish_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              write_ones_o,
  output logic              cmp_en_o,
  output logic              expect_ones_o
);

  localparam int unsigned SEG_W = ADDR_W - WIN_W;

  logic              run_q;
  logic              done_q;
  logic              half_q;
  pass_idx_t         pass_q;
  logic [SEG_W-1:0]  seg_q;
  logic [WIN_W-1:0]  cnt_q;

  // named internal events
  logic              reads;
  logic              desc;
  logic              addr_step;
  logic              cnt_wrap;
  logic              pass_wrap;
  logic              seg_wrap;
  logic              accept;
  logic              finish;
  logic [WIN_W-1:0]  offset;

  assign reads     = pass_reads(pass_q);
  assign desc      = pass_is_desc(pass_q);
  assign addr_step = !reads || half_q;
  assign cnt_wrap  = &cnt_q;
  assign pass_wrap = (pass_q == PASS_LAST);
  assign seg_wrap  = &seg_q;
  assign accept    = start_i && !run_q;
  assign finish    = run_q && addr_step && cnt_wrap && pass_wrap && seg_wrap;
  assign offset    = desc ? ~cnt_q : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      pass_q <= PASS_FIRST;
      seg_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= finish;
      if (accept) begin
        run_q  <= 1'b1;
        half_q <= 1'b0;
        pass_q <= PASS_FIRST;
        seg_q  <= '0;
        cnt_q  <= '0;
      end else if (run_q) begin
        half_q <= reads ? ~half_q : 1'b0;
        if (addr_step) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_wrap) begin
            pass_q <= pass_wrap ? PASS_FIRST : pass_q + 1'b1;
            if (pass_wrap) seg_q <= seg_q + 1'b1;
          end
        end
        if (finish) run_q <= 1'b0;
      end
    end
  end

  assign busy_o        = run_q;
  assign done_o        = done_q;
  assign accept_o      = accept;
  assign finish_o      = finish;
  assign addr_o        = {seg_q, offset};
  assign we_o          = run_q && addr_step;
  assign write_ones_o  = pass_write_ones(pass_q);
  assign cmp_en_o      = run_q && reads && half_q;
  assign expect_ones_o = pass_expect_ones(pass_q);

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !we_o) |=> (we_o && addr_o == $past(addr_o)));  // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R10

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start_i) |=> !(run_q && pass_q == PASS_FIRST && seg_q == '0 && cnt_q == '0));  // R11

  AST_FILL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && pass_q == PASS_FIRST) |-> (we_o && !cmp_en_o));  // R1

endmodule

// File: rtl/march_check.sv
module march_check
  import march_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned BANK_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic                 cmp_en_i,
  input  logic                 expect_ones_i,
  input  logic                 finish_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    rdata_i,
  output logic [DATA_W-1:0]    err_mask_o,
  output logic [ADDR_W-1:0]    fail_addr_o,
  output logic [(1<<BANK_W)-1:0] bank_bad_o,
  output logic                 pass_ok_o
);

  localparam int unsigned NBANK = 1 << BANK_W;

  logic [DATA_W-1:0] expect_word;
  logic [DATA_W-1:0] diff;
  logic              hit;
  logic [BANK_W-1:0] bank_sel;
  logic [NBANK-1:0]  bank_hit;

  logic [DATA_W-1:0] err_mask_q;
  logic [ADDR_W-1:0] fail_addr_q;
  logic [NBANK-1:0]  bank_q;
  logic              any_err_q;
  logic              pass_ok_q;

  assign expect_word = {DATA_W{expect_ones_i}};
  assign diff        = rdata_i ^ expect_word;
  assign hit         = cmp_en_i && (|diff);
  assign bank_sel    = addr_i[ADDR_W-1 -: BANK_W];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_hit[b] = hit && (bank_sel == BANK_W'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mask_q  <= '0;
      fail_addr_q <= '0;
      bank_q      <= '0;
      any_err_q   <= 1'b0;
      pass_ok_q   <= 1'b0;
    end else if (clear_i) begin
      err_mask_q  <= '0;
      fail_addr_q <= '0;
      bank_q      <= '0;
      any_err_q   <= 1'b0;
      pass_ok_q   <= 1'b0;
    end else begin
      bank_q <= bank_q | bank_hit;
      if (hit) begin
        err_mask_q <= err_mask_q | diff;
        any_err_q  <= 1'b1;
        if (!any_err_q) fail_addr_q <= addr_i;
      end
      if (finish_i) pass_ok_q <= !(any_err_q || hit);
    end
  end

  assign err_mask_o  = err_mask_q;
  assign fail_addr_o = fail_addr_q;
  assign bank_bad_o  = bank_q;
  assign pass_ok_o   = pass_ok_q;

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clear_i) |-> ((err_mask_q & $past(err_mask_q)) == $past(err_mask_q)));  // R7

  AST_FIRST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err_q && $past(any_err_q) && !$past(clear_i)) |-> $stable(fail_addr_q));  // R8

  AST_BANK_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mask_q == '0) |-> (bank_q == '0));  // R9

endmodule

// File: rtl/march_tester.sv
module march_tester
  import march_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WIN_W  = 4,
  parameter int unsigned BANK_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   busy,
  output logic                   done,
  output logic                   pass_ok,
  output logic [ADDR_W-1:0]      fail_addr,
  output logic [DATA_W-1:0]      err_bits,
  output logic [(1<<BANK_W)-1:0] bank_bad,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_we,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata
);

  logic accept;
  logic finish;
  logic write_ones;
  logic cmp_en;
  logic expect_ones;

  march_seq #(
    .ADDR_W (ADDR_W),
    .WIN_W  (WIN_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .busy_o        (busy),
    .done_o        (done),
    .accept_o      (accept),
    .finish_o      (finish),
    .addr_o        (mem_addr),
    .we_o          (mem_we),
    .write_ones_o  (write_ones),
    .cmp_en_o      (cmp_en),
    .expect_ones_o (expect_ones)
  );

  assign mem_wdata = mem_we ? {DATA_W{write_ones}} : '0;

  march_check #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
  ) u_check (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (accept),
    .cmp_en_i      (cmp_en),
    .expect_ones_i (expect_ones),
    .finish_i      (finish),
    .addr_i        (mem_addr),
    .rdata_i       (mem_rdata),
    .err_mask_o    (err_bits),
    .fail_addr_o   (fail_addr),
    .bank_bad_o    (bank_bad),
    .pass_ok_o     (pass_ok)
  );

  AST_PASS_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass_ok == (err_bits == '0)));  // R10

  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (mem_wdata == '0));  // R12

endmodule

// File: tb/march_tester_tb.sv
`timescale 1ns/1ps
module march_tester_tb;

  localparam int DW      = 16;
  localparam int AW      = 6;
  localparam int WW      = 4;
  localparam int BW      = 1;
  localparam int WORDS   = 1 << WW;
  localparam int NSEG    = 1 << (AW - WW);
  localparam int DEPTH   = 1 << AW;
  localparam int NBANK   = 1 << BW;
  localparam int N_STEPS = NSEG * 9 * WORDS;
  localparam int MAXOPS  = 1024;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              busy, done, pass_ok, mem_we;
  logic [AW-1:0]     fail_addr, mem_addr;
  logic [DW-1:0]     err_bits, mem_wdata;
  logic [DW-1:0]     mem_rdata = '0;
  logic [NBANK-1:0]  bank_bad;

  always #2 clk = ~clk;

  march_tester #(.DATA_W(DW), .ADDR_W(AW), .WIN_W(WW), .BANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass_ok(pass_ok), .fail_addr(fail_addr), .err_bits(err_bits),
    .bank_bad(bank_bad), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // RAM model with stuck-at cells applied on read
  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] s0  [DEPTH];
  logic [DW-1:0] s1  [DEPTH];

  always @(posedge clk) begin
    mem_rdata <= (ram[mem_addr] & ~s0[mem_addr]) | s1[mem_addr];
    if (mem_we) ram[mem_addr] <= mem_wdata;
  end

  // operation log
  logic [AW-1:0] l_addr [MAXOPS];
  logic          l_we   [MAXOPS];
  logic [DW-1:0] l_wd   [MAXOPS];
  int            l_n;

  always @(negedge clk) begin
    if (busy && l_n < MAXOPS) begin
      l_addr[l_n] = mem_addr;
      l_we[l_n]   = mem_we;
      l_wd[l_n]   = mem_wdata;
      l_n++;
    end
  end

  // expected march
  logic [AW-1:0] e_addr [MAXOPS];
  logic          e_we   [MAXOPS];
  logic [DW-1:0] e_wd   [MAXOPS];
  int            e_pass [MAXOPS];
  int            e_n;
  logic [DW-1:0] x_mask;
  logic [AW-1:0] x_first;
  logic [NBANK-1:0] x_bank;
  bit            x_fail;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push_op(input logic [AW-1:0] a, input logic we,
                                  input logic [DW-1:0] wd, input int p);
    e_addr[e_n] = a; e_we[e_n] = we; e_wd[e_n] = wd; e_pass[e_n] = p;
    e_n++;
  endfunction

  function automatic void predict();
    logic [DW-1:0] mm [DEPTH];
    for (int k = 0; k < DEPTH; k++) mm[k] = '0;
    e_n = 0; x_mask = '0; x_first = '0; x_bank = '0; x_fail = 1'b0;
    for (int seg = 0; seg < NSEG; seg++) begin
      for (int p = 0; p < 5; p++) begin
        for (int i = 0; i < WORDS; i++) begin
          int off;
          logic [AW-1:0] a;
          logic [DW-1:0] wv, ev, got;
          off = (p == 1 || p == 4) ? (WORDS - 1 - i) : i;
          a   = AW'(seg * WORDS + off);
          wv  = (p == 1 || p == 3) ? '1 : '0;
          if (p != 0) begin
            ev  = (p == 2 || p == 4) ? '1 : '0;
            got = (mm[a] & ~s0[a]) | s1[a];
            push_op(a, 1'b0, '0, p);
            if (got != ev) begin
              x_mask = x_mask | (got ^ ev);
              if (!x_fail) x_first = a;
              x_fail = 1'b1;
              x_bank[a >> (AW - BW)] = 1'b1;
            end
          end
          push_op(a, 1'b1, wv, p);
          mm[a] = wv;
        end
      end
    end
  endfunction

  function automatic void clear_faults();
    for (int k = 0; k < DEPTH; k++) begin s0[k] = '0; s1[k] = '0; end
  endfunction

  function automatic void add_fault(input int a, input int b, input bit one);
    if (one) begin s1[a][b] = 1'b1; s0[a][b] = 1'b0; end
    else     begin s0[a][b] = 1'b1; s1[a][b] = 1'b0; end
  endfunction

  task automatic run_march(input string tag, input bit poke);
    int cyc;
    int perr [5];
    string ptag [5];
    logic [DW-1:0] hold_mask;
    ptag[0] = "R1"; ptag[1] = "R2"; ptag[2] = "R3"; ptag[3] = "R4"; ptag[4] = "R5";
    predict();
    l_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 100) start = 1'b1;   // R11 start while busy
      if (poke && cyc == 101) start = 1'b0;
    end
    if (cyc >= 5000) begin
      chk(1'b0, "R6", {tag, " watchdog, done never seen"}, 64'(cyc), 64'(N_STEPS));
      return;
    end
    chk(cyc == N_STEPS, "R6", {tag, " cycles to done"}, 64'(cyc), 64'(N_STEPS));
    chk(l_n == e_n, "R6", {tag, " RAM operation count"}, 64'(l_n), 64'(e_n));
    for (int p = 0; p < 5; p++) perr[p] = 0;
    for (int k = 0; k < e_n; k++) begin
      if (k >= l_n || l_addr[k] !== e_addr[k] || l_we[k] !== e_we[k] ||
          l_wd[k] !== e_wd[k])
        perr[e_pass[k]]++;
    end
    for (int p = 0; p < 5; p++)
      chk(perr[p] == 0, ptag[p], {tag, " pass operation mismatches"}, 64'(perr[p]), 64'd0);
    chk(pass_ok == !x_fail, "R10", {tag, " pass_ok"}, 64'(pass_ok), 64'(!x_fail));
    chk(err_bits == x_mask, "R7", {tag, " err_bits"}, 64'(err_bits), 64'(x_mask));
    if (x_fail)
      chk(fail_addr == x_first, "R8", {tag, " fail_addr"}, 64'(fail_addr), 64'(x_first));
    chk(bank_bad == x_bank, "R9", {tag, " bank_bad"}, 64'(bank_bad), 64'(x_bank));
    hold_mask = err_bits;
    repeat (3) @(negedge clk);
    chk(!done && !busy, "R10", {tag, " done single cycle"}, 64'({done, busy}), 64'd0);
    chk(err_bits == hold_mask && pass_ok == !x_fail, "R10", {tag, " results held"},
        64'(err_bits), 64'(hold_mask));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL R6 global watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    l_n = 0;
    void'($urandom(32'h1d5a_7e03));
    for (int k = 0; k < DEPTH; k++) ram[k] = DW'($urandom);
    clear_faults();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk({busy, done, pass_ok, mem_we} == 4'b0 && err_bits == '0 &&
        fail_addr == '0 && bank_bad == '0, "R12", "reset state",
        64'({busy, done, pass_ok, mem_we, err_bits}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_we, "R12", "idle after reset", 64'({busy, mem_we}), 64'd0);

    run_march("clean", 1'b0);

    clear_faults(); add_fault(0, 0, 1'b1);
    run_march("stuck1 addr0 bit0", 1'b0);

    clear_faults(); add_fault(DEPTH - 1, DW - 1, 1'b0);
    run_march("stuck0 top addr bit15", 1'b0);

    clear_faults(); add_fault(5, 3, 1'b1); add_fault(40, 9, 1'b0); add_fault(20, 3, 1'b0);
    run_march("both banks", 1'b0);

    clear_faults();
    run_march("R11 clear after faults", 1'b0);

    run_march("R11 start while busy", 1'b1);

    for (int r = 0; r < 6; r++) begin
      int nf;
      clear_faults();
      nf = 1 + int'($urandom % 3);
      for (int f = 0; f < nf; f++)
        add_fault(int'($urandom % DEPTH), int'($urandom % DW), bit'($urandom % 2));
      run_march($sformatf("random %0d", r), 1'b0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule